// File: doc/BRIEF.md
# Long-Literal Operand Selector

This block builds the source operands of one instruction syllable. The second source can come from several places: a literal word carried with the instruction bundle, a short immediate held in the specifier itself, or a register. The first source can be a 5-bit immediate or a register. Register values are read elsewhere. For a register specifier the block only reports that a register is wanted and which index.

Literals are taken from up to four 32-bit slots, and each slot has a present flag. The second-source specifier sits in syllable bits 15:8. When it names a literal, it also picks a form and a slot. The form is a zero-extended low half, a zero-extended high half, the whole word, or a 64-bit value built from two adjacent slots. Some forms are legal only in certain slots. If the form is used in the wrong slot, or a slot it needs is missing, the block raises an error flag and returns a zero operand.

All results are registered and appear one cycle after the syllable is accepted.

Top module: `lit_operand_sel`

## Requirements
- R1: While `rst` is high and after it falls, `out_valid`, `src2_err`, both operands and both register-select outputs are 0 until the first accepted syllable.
- R2: A syllable presented with `in_valid` high gives results with `out_valid` high on the next cycle. When `in_valid` is low, `out_valid` goes low on the next cycle and every result output keeps its value.
- R3: The second-source specifier `1101_00ss` (low-half form, slot `ss`) returns bits 15:0 of slot `ss`, zero-extended to 64 bits.
- R4: The specifier `1101_01ss` (high-half form) returns bits 31:16 of slot `ss`, zero-extended to 64 bits.
- R5: The specifier `1101_10ss` (word form) returns all 32 bits of slot `ss`, zero-extended, for any slot 0..3.
- R6: The specifier `1101_11ss` (pair form) returns slot `ss+1` in bits 63:32 and slot `ss` in bits 31:0.
- R7: The low-half and high-half forms are legal only for slots 0 and 1. The pair form is legal only for slots 0 to 2. Any other slot sets `src2_err`.
- R8: If the referenced slot is not present, `src2_err` is set. For the pair form, `src2_err` is also set when slot `ss+1` is not present. Present flags are `lit_present[i]` for slot i, and slot i is `lit_words[32*i+31:32*i]`.
- R9: Whenever `src2_err` is 1, `src2_operand` is 0 and `src2_reg_sel` is 0.
- R10: The specifier `1100_iiii` returns the 4-bit immediate `iiii`, zero-extended, with no error.
- R11: A specifier with bit 7 clear sets `src2_reg_sel`, puts bits 6:0 on `src2_reg_idx`, drives a zero operand and raises no error.
- R12: The specifier codes `10xx_xxxx` and `111x_xxxx` are reserved and set `src2_err`.
- R13: The first-source specifier is in syllable bits 23:16. The code `110i_iiii` gives the 5-bit immediate zero-extended on `src1_operand`. Bit 7 clear sets `src1_reg_sel` with bits 6:0 as the index. Every other code gives zero with no register select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Syllable and literals are valid this cycle |
| syllable | input | 32 | Instruction syllable; bits 23:16 first source, bits 15:8 second source |
| lit_words | input | 128 | Four literal slots, slot i in bits 32*i+31:32*i |
| lit_present | input | 4 | Present flag per literal slot |
| out_valid | output | 1 | Registered results are valid |
| src2_operand | output | 64 | Second-source operand value |
| src2_err | output | 1 | Illegal second-source operand |
| src2_reg_sel | output | 1 | Second source is a register |
| src2_reg_idx | output | 7 | Register index for the second source |
| src1_operand | output | 64 | First-source immediate value |
| src1_reg_sel | output | 1 | First source is a register |
| src1_reg_idx | output | 7 | Register index for the first source |

## Verification
The presence assertion assumes the present flags and literal words are stable for the whole cycle in which `in_valid` is high. It also relies on the syllable's slot field indexing the same flag bit that the block decodes. The hold assertion assumes that nothing but `in_valid` gates an update. The stimulus drives each syllable together with its literals and flags on the falling edge and changes them only when the next syllable is driven. It drops `in_valid` before it scrambles the inputs to probe the hold behaviour. The vectors cover every form in legal and illegal slots, with one slot withdrawn.

// File: rtl/lit_sel_pkg.sv
package lit_sel_pkg;

    localparam int LIT_W      = 32;
    localparam int NUM_SLOTS  = 4;
    localparam int OP_W       = 2 * LIT_W;
    localparam int SPEC_W     = 8;
    localparam int REG_IDX_W  = 7;
    localparam int SLOT_FLD_W = 2;
    localparam int IMM4_W     = 4;
    localparam int IMM5_W     = 5;

    typedef enum logic [1:0] {
        FORM_LO_HALF = 2'd0,
        FORM_HI_HALF = 2'd1,
        FORM_WORD    = 2'd2,
        FORM_PAIR    = 2'd3
    } lit_form_e;

    typedef enum logic [1:0] {
        KIND_REG,
        KIND_IMM,
        KIND_LIT,
        KIND_RSVD
    } spec_kind_e;

    typedef struct packed {
        spec_kind_e             kind;
        lit_form_e              form;
        logic [SLOT_FLD_W-1:0]  slot;
        logic [REG_IDX_W-1:0]   reg_idx;
        logic [IMM4_W-1:0]      imm;
    } src2_dec_t;

    typedef struct packed {
        logic [OP_W-1:0]      value;
        logic                 reg_sel;
        logic [REG_IDX_W-1:0] reg_idx;
        logic                 err;
    } operand_t;

    function automatic src2_dec_t decode_src2(input logic [SPEC_W-1:0] s);
        src2_dec_t d;
        d.form    = lit_form_e'(s[3:2]);
        d.slot    = s[1:0];
        d.reg_idx = s[6:0];
        d.imm     = s[3:0];
        if (!s[7])                  d.kind = KIND_REG;
        else if (s[6:4] == 3'b100)  d.kind = KIND_IMM;
        else if (s[6:4] == 3'b101)  d.kind = KIND_LIT;
        else                        d.kind = KIND_RSVD;
        return d;
    endfunction

    function automatic operand_t decode_src1(input logic [SPEC_W-1:0] s);
        operand_t r;
        r = '0;
        if (!s[7]) begin
            r.reg_sel = 1'b1;
            r.reg_idx = s[6:0];
        end else if (s[6:5] == 2'b10) begin
            r.value = {{(OP_W-IMM5_W){1'b0}}, s[IMM5_W-1:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/lit_slot_fetch.sv
module lit_slot_fetch
    import lit_sel_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int WW    = LIT_W
) (
    input  logic [NSLOT*WW-1:0]        words_flat,
    input  logic [NSLOT-1:0]           present,
    input  lit_form_e                  form,
    input  logic [$clog2(NSLOT)-1:0]   slot,
    output logic [2*WW-1:0]            value,
    output logic                       err
);
    localparam int SW     = $clog2(NSLOT);
    localparam int HALF_W = WW / 2;
    localparam logic [SW-1:0] HALF_LIMIT = SW'(2);
    localparam logic [SW-1:0] PAIR_LIMIT = SW'(NSLOT - 1);

    logic [WW-1:0] word_at  [NSLOT];
    logic [WW-1:0] upper_at [NSLOT];
    logic          upper_ok [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign word_at[g] = words_flat[g*WW +: WW];
        if (g < NSLOT - 1) begin : g_has_upper
            assign upper_at[g] = words_flat[(g+1)*WW +: WW];
            assign upper_ok[g] = present[g+1];
        end else begin : g_no_upper
            assign upper_at[g] = '0;
            assign upper_ok[g] = 1'b0;
        end
    end

    logic [WW-1:0] base;
    logic          slot_ok;

    always_comb begin
        base    = word_at[slot];
        value   = '0;
        slot_ok = 1'b0;
        unique case (form)
            FORM_LO_HALF: begin
                value   = {{(2*WW-HALF_W){1'b0}}, base[HALF_W-1:0]};
                slot_ok = (slot < HALF_LIMIT);
            end
            FORM_HI_HALF: begin
                value   = {{(2*WW-HALF_W){1'b0}}, base[WW-1:HALF_W]};
                slot_ok = (slot < HALF_LIMIT);
            end
            FORM_WORD: begin
                value   = {{WW{1'b0}}, base};
                slot_ok = 1'b1;
            end
            FORM_PAIR: begin
                value   = {upper_at[slot], base};
                slot_ok = (slot < PAIR_LIMIT) && upper_ok[slot];
            end
            default: ;
        endcase
        err = !(slot_ok && present[slot]);
    end

endmodule

// File: rtl/lit_src2_path.sv
module lit_src2_path
    import lit_sel_pkg::*;
(
    input  logic [SPEC_W-1:0]          spec,
    input  logic [NUM_SLOTS*LIT_W-1:0] words_flat,
    input  logic [NUM_SLOTS-1:0]       present,
    output operand_t                   result
);
    src2_dec_t       dec;
    logic [OP_W-1:0] lit_value;
    logic            lit_err;

    assign dec = decode_src2(spec);

    lit_slot_fetch #(.NSLOT(NUM_SLOTS), .WW(LIT_W)) u_fetch (
        .words_flat (words_flat),
        .present    (present),
        .form       (dec.form),
        .slot       (dec.slot),
        .value      (lit_value),
        .err        (lit_err)
    );

    operand_t raw;

    always_comb begin
        raw = '0;
        unique case (dec.kind)
            KIND_REG: begin
                raw.reg_sel = 1'b1;
                raw.reg_idx = dec.reg_idx;
            end
            KIND_IMM:  raw.value = {{(OP_W-IMM4_W){1'b0}}, dec.imm};
            KIND_LIT: begin
                raw.value = lit_value;
                raw.err   = lit_err;
            end
            KIND_RSVD: raw.err = 1'b1;
            default: ;
        endcase
        result = raw.err ? operand_t'({{(OP_W+REG_IDX_W+1){1'b0}}, 1'b1}) : raw;
    end

endmodule

// File: rtl/lit_src1_path.sv
module lit_src1_path
    import lit_sel_pkg::*;
(
    input  logic [SPEC_W-1:0] spec,
    output operand_t          result
);
    assign result = decode_src1(spec);
endmodule

// File: rtl/lit_operand_sel.sv
module lit_operand_sel
    import lit_sel_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [31:0]                  syllable,
    input  logic [NUM_SLOTS*LIT_W-1:0]   lit_words,
    input  logic [NUM_SLOTS-1:0]         lit_present,
    output logic                         out_valid,
    output logic [OP_W-1:0]              src2_operand,
    output logic                         src2_err,
    output logic                         src2_reg_sel,
    output logic [REG_IDX_W-1:0]         src2_reg_idx,
    output logic [OP_W-1:0]              src1_operand,
    output logic                         src1_reg_sel,
    output logic [REG_IDX_W-1:0]         src1_reg_idx
);
    localparam int SRC2_LSB = 8;
    localparam int SRC1_LSB = 16;

    operand_t s2_next, s1_next;
    operand_t s2_q, s1_q;
    logic     valid_q;

    lit_src2_path u_src2 (
        .spec       (syllable[SRC2_LSB +: SPEC_W]),
        .words_flat (lit_words),
        .present    (lit_present),
        .result     (s2_next)
    );

    lit_src1_path u_src1 (
        .spec   (syllable[SRC1_LSB +: SPEC_W]),
        .result (s1_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            s2_q    <= '0;
            s1_q    <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                s2_q <= s2_next;
                s1_q <= s1_next;
            end
        end
    end

    assign out_valid    = valid_q;
    assign src2_operand = s2_q.value;
    assign src2_err     = s2_q.err;
    assign src2_reg_sel = s2_q.reg_sel;
    assign src2_reg_idx = s2_q.reg_idx;
    assign src1_operand = s1_q.value;
    assign src1_reg_sel = s1_q.reg_sel;
    assign src1_reg_idx = s1_q.reg_idx;

endmodule

// File: rtl/lit_operand_sel_chk.sv
module lit_operand_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] syllable,
    input logic [3:0]  lit_present,
    input logic        out_valid,
    input logic [63:0] src2_operand,
    input logic        src2_err,
    input logic        src2_reg_sel,
    input logic [63:0] src1_operand
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !src2_err && src2_operand == 64'd0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(src2_operand) && $stable(src1_operand)));

    a_r9_err_zeroes: assert property (@(posedge clk) disable iff (rst)
        src2_err |-> (src2_operand == 64'd0 && !src2_reg_sel));

    a_r8_absent_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && syllable[15:10] == 6'b110110 && !lit_present[syllable[9:8]])
        |=> src2_err);

    a_r12_reserved: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (syllable[15:14] == 2'b10 || syllable[15:13] == 3'b111))
        |=> src2_err);

    a_r11_reg_no_err: assert property (@(posedge clk) disable iff (rst)
        src2_reg_sel |-> !src2_err);
endmodule

bind lit_operand_sel lit_operand_sel_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .syllable     (syllable),
    .lit_present  (lit_present),
    .out_valid    (out_valid),
    .src2_operand (src2_operand),
    .src2_err     (src2_err),
    .src2_reg_sel (src2_reg_sel),
    .src1_operand (src1_operand)
);

// File: tb/lit_operand_sel_test.sv
`timescale 1ns/1ps
module lit_operand_sel_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  syllable = '0;
    logic [127:0] lit_words = '0;
    logic [3:0]   lit_present = '0;
    logic         out_valid;
    logic [63:0]  src2_operand, src1_operand;
    logic         src2_err, src2_reg_sel, src1_reg_sel;
    logic [6:0]   src2_reg_idx, src1_reg_idx;

    always #4 clk = ~clk;

    lit_operand_sel uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .syllable(syllable),
        .lit_words(lit_words), .lit_present(lit_present),
        .out_valid(out_valid), .src2_operand(src2_operand), .src2_err(src2_err),
        .src2_reg_sel(src2_reg_sel), .src2_reg_idx(src2_reg_idx),
        .src1_operand(src1_operand), .src1_reg_sel(src1_reg_sel),
        .src1_reg_idx(src1_reg_idx)
    );

    typedef struct {
        logic [63:0] v2;
        logic        e2;
        logic        rs2;
        logic [6:0]  ri2;
        logic [63:0] v1;
        logic        rs1;
        logic [6:0]  ri1;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] lw [4];
    exp_t last_exp;

    function automatic exp_t model(logic [7:0] s1, logic [7:0] s2, logic [3:0] pres, string tag);
        exp_t e;
        int k;
        bit ok;
        e.v2 = 0; e.e2 = 0; e.rs2 = 0; e.ri2 = 0;
        e.v1 = 0; e.rs1 = 0; e.ri1 = 0; e.tag = tag;
        if (s2[7] == 1'b0) begin
            e.rs2 = 1; e.ri2 = s2[6:0];
        end else if (s2[7:4] == 4'hC) begin
            e.v2 = 64'(s2[3:0]);
        end else if (s2[7:4] == 4'hD) begin
            k = int'(s2[1:0]);
            ok = pres[k];
            case (s2[3:2])
                2'd0: begin ok = ok && (k < 2); e.v2 = 64'(lw[k] & 32'h0000_FFFF); end
                2'd1: begin ok = ok && (k < 2); e.v2 = 64'(lw[k] >> 16); end
                2'd2: e.v2 = 64'(lw[k]);
                default: begin
                    ok = ok && (k < 3) && (k < 3 ? pres[k+1] : 1'b0);
                    e.v2 = (k < 3) ? {lw[k+1], lw[k]} : 64'd0;
                end
            endcase
            if (!ok) begin e.e2 = 1; e.v2 = 0; end
        end else begin
            e.e2 = 1;
        end
        if (s1[7] == 1'b0) begin
            e.rs1 = 1; e.ri1 = s1[6:0];
        end else if (s1[7:5] == 3'b110) begin
            e.v1 = 64'(s1[4:0]);
        end
        return e;
    endfunction

    task automatic send(input logic [7:0] s1, input logic [7:0] s2,
                        input logic [3:0] pres, input string tag);
        @(negedge clk);
        in_valid    = 1'b1;
        syllable    = {8'h00, s1, s2, 8'h00};
        lit_present = pres;
        q.push_back(model(s1, s2, pres, tag));
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2: result with no pending item, act=%h exp=none", src2_operand);
            end else begin
                e = q.pop_front();
                last_exp = e;
                if (src2_operand !== e.v2 || src2_err !== e.e2 ||
                    src2_reg_sel !== e.rs2 || src2_reg_idx !== e.ri2) begin
                    errors++;
                    $display("FAIL %s src2: act=%h/%b/%b/%h exp=%h/%b/%b/%h", e.tag,
                             src2_operand, src2_err, src2_reg_sel, src2_reg_idx,
                             e.v2, e.e2, e.rs2, e.ri2);
                end
                checks++;
                if (src1_operand !== e.v1 || src1_reg_sel !== e.rs1 || src1_reg_idx !== e.ri1) begin
                    errors++;
                    $display("FAIL %s src1 (R13): act=%h/%b/%h exp=%h/%b/%h", e.tag,
                             src1_operand, src1_reg_sel, src1_reg_idx, e.v1, e.rs1, e.ri1);
                end
            end
        end
    end

    task automatic check(input bit cond, input string msg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", msg, act, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, act=running exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        lw[0] = 32'hA1B2_C3D4;
        lw[1] = 32'h1357_9BDF;
        lw[2] = 32'h0F1E_2D3C;
        lw[3] = 32'h8899_AABB;
        lit_words = {lw[3], lw[2], lw[1], lw[0]};
        lit_present = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset state while rst high
        check(!out_valid && !src2_err && src2_operand == 0 && src1_operand == 0 &&
              !src2_reg_sel && !src1_reg_sel, "R1 in reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && src2_operand == 0 && !src2_err, "R1 after release",
              src2_operand, 64'd0);

        send(8'hDF, 8'hD0, 4'hF, "R3 lo slot0");
        send(8'h22, 8'hD1, 4'hF, "R3 lo slot1");
        send(8'hC5, 8'hD4, 4'hF, "R4 hi slot0");
        send(8'hF0, 8'hD5, 4'hF, "R4 hi slot1");
        send(8'h00, 8'hDB, 4'hF, "R5 word slot3");
        send(8'h7F, 8'hDA, 4'hF, "R5 word slot2");
        send(8'hC0, 8'hDC, 4'hF, "R6 pair slot0");
        send(8'hC1, 8'hDE, 4'hF, "R6 pair slot2");
        send(8'h00, 8'hD2, 4'hF, "R7 lo slot2");
        send(8'h00, 8'hD7, 4'hF, "R7 hi slot3");
        send(8'h00, 8'hDF, 4'hF, "R7 pair slot3");
        send(8'h00, 8'hD8, 4'b1110, "R8 word slot0 absent");
        send(8'h00, 8'hDC, 4'b1101, "R8 pair upper absent");
        send(8'h00, 8'hDE, 4'b1101, "R8 pair slot2 ok");
        send(8'h00, 8'hD5, 4'b1101, "R9 hi absent zeroed");
        send(8'h00, 8'hCF, 4'hF, "R10 imm4");
        send(8'h00, 8'hC3, 4'h0, "R10 imm4 no literals");
        send(8'h00, 8'h45, 4'hF, "R11 register");
        send(8'h00, 8'h9A, 4'hF, "R12 reserved 10xx");
        send(8'h00, 8'hE3, 4'hF, "R12 reserved 111x");
        send(8'hA0, 8'hD0, 4'hF, "R13 src1 other code");

        // R2: drop in_valid and scramble inputs
        @(negedge clk);
        in_valid = 1'b0;
        syllable = 32'h00FF_CF00;
        lit_present = 4'h0;
        @(negedge clk);
        @(negedge clk);
        check(!out_valid, "R2 idle out_valid low", {63'd0, out_valid}, 64'd0);
        check(src2_operand == last_exp.v2 && src1_operand == last_exp.v1,
              "R2 outputs held while idle", src2_operand, last_exp.v2);
        check(q.size() == 0, "R2 all results delivered", 64'(q.size()), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule